// File: doc/BRIEF.md
# Command-Queue DMA Register Front End

This block is the register face of a DMA engine that works through a ring of fixed-size command slots held in memory. Software programs a queue base address and an end offset. It rings a doorbell by writing the write pointer in byte units, four bytes per slot, and bit 31 of that doorbell write gives the direction of the transfer. A write pointer that differs from the read pointer starts a transfer and raises the in-progress flag. A stub consumer then moves the read pointer forward by one slot each cycle, wrapping at the end offset. When the read pointer reaches the write pointer, the consumer posts a completion in the direction of the active transfer.

The data mover can also report completions through two pulse inputs, one for each direction. A completion of either direction always sets its sticky status bit. It ends the transfer only when its direction matches the active one. Status bits are cleared by writing one to them. The interrupt line follows the status bits that software has enabled in the control register. After reset the control register reads zero, which software takes as "engine not initialised".

Top module: `dmaq_regs`

## Requirements
- R1: After reset every register reads zero (including control, which signals an uninitialised engine), and `busy` and `irq` are low.
- R2: The queue base register (offset 0x10) keeps all 32 written bits. The end register (offset 0x14) keeps the low PW bits.
- R3: The control register (offset 0x20) keeps only bits 4, 5, 6, 17 to 19, 28 and 29, and every other bit reads zero. Bit 4 enables the upstream interrupt and bit 5 the downstream one. Bits 19:17 hold a request-size code: 0 is 128 bytes, 1 is 256, up to 5 for 4K; 6 and 7 are reserved.
- R4: Writing 0xEE882266 to the read pointer (offset 0x1C) sets it to zero. Any other value written there is ignored.
- R5: A write to offset 0x18 stores bits PW-1:0 as the write pointer and bit 31 as the direction (1 is upstream). It raises `busy` at the next edge when the value differs from the read pointer, and leaves `busy` low when the value equals it.
- R6: While `busy` is high and the two pointers differ, the read pointer advances by 4 per cycle, wrapping to 0 where the next value would equal the end offset. While `busy` is low it holds.
- R7: When the read pointer equals the write pointer during a transfer, the next edge clears `busy` and sets status bit 4 for an upstream transfer or bit 5 for a downstream one. The status register is at offset 0x24.
- R8: A pulse on `done_up` sets status bit 4, and a pulse on `done_dn` sets status bit 5. Either pulse clears `busy` only when its direction matches the active direction; otherwise the transfer carries on.
- R9: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R10: `irq` is high exactly when a status bit is set and its enable bit in control is set.
- R11: Reads of offsets not listed above return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, one write per asserted cycle |
| bus_addr | input | AW | Register byte offset for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| done_up | input | 1 | Upstream completion pulse from the data mover |
| done_dn | input | 1 | Downstream completion pulse from the data mover |
| busy | output | 1 | Transfer in progress |
| dir_up | output | 1 | Direction of the current or last transfer, 1 is upstream |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that the end offset is a nonzero multiple of 4 and that both pointers stay below it. They also assume that each completion input is a pulse of one cycle. The bench programs only aligned pointers that lie inside the configured ring, and it raises each completion input for exactly one clock. The stall case, where a completion of the wrong direction arrives, is driven while a long transfer still has many slots left, so the drain can never coincide with that pulse.

// File: rtl/dmaq_regs.sv
module dmaq_regs #(
  parameter int AW = 8,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          done_up,
  input  logic          done_dn,
  output logic          busy,
  output logic          dir_up,
  output logic          irq
);

  localparam logic [AW-1:0] OFF_BASE = AW'(8'h10);
  localparam logic [AW-1:0] OFF_END  = AW'(8'h14);
  localparam logic [AW-1:0] OFF_WP   = AW'(8'h18);
  localparam logic [AW-1:0] OFF_RP   = AW'(8'h1C);
  localparam logic [AW-1:0] OFF_CTRL = AW'(8'h20);
  localparam logic [AW-1:0] OFF_STAT = AW'(8'h24);
  localparam logic [31:0]   RP_CLEAR = 32'hEE88_2266;
  localparam logic [31:0]   CTRL_KEEP = 32'h300E_0070;
  localparam logic [PW-1:0] SLOT = PW'(4);

  logic [31:0]   base_q, ctrl_q;
  logic [PW-1:0] endp_q, wptr_q, rptr_q;
  logic          busy_q, dir_q;
  logic [1:0]    st_q;

  wire wr_base = bus_we && bus_addr == OFF_BASE;
  wire wr_end  = bus_we && bus_addr == OFF_END;
  wire wr_wp   = bus_we && bus_addr == OFF_WP;
  wire wr_rp   = bus_we && bus_addr == OFF_RP;
  wire wr_ctrl = bus_we && bus_addr == OFF_CTRL;
  wire wr_st   = bus_we && bus_addr == OFF_STAT;

  wire clr_rp = wr_rp && bus_wdata == RP_CLEAR;
  wire ring   = wr_wp && bus_wdata[PW-1:0] != rptr_q;
  wire step   = busy_q && rptr_q != wptr_q;
  wire drained = busy_q && rptr_q == wptr_q && !wr_wp;

  logic [PW-1:0] rp_inc, rp_next;
  assign rp_inc  = rptr_q + SLOT;
  assign rp_next = (rp_inc == endp_q) ? '0 : rp_inc;

  wire set_up = done_up || (drained && dir_q);
  wire set_dn = done_dn || (drained && !dir_q);
  wire finish = drained || (done_up && dir_q) || (done_dn && !dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ctrl_q <= '0;
      endp_q <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      st_q   <= '0;
    end else begin
      if (wr_base) base_q <= bus_wdata;
      if (wr_end)  endp_q <= bus_wdata[PW-1:0];
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
      if (wr_wp) begin
        wptr_q <= bus_wdata[PW-1:0];
        dir_q  <= bus_wdata[31];
      end
      if (clr_rp)    rptr_q <= '0;
      else if (step) rptr_q <= rp_next;
      if (ring)        busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      st_q <= (st_q & ~({2{wr_st}} & bus_wdata[5:4])) | {set_dn, set_up};
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_BASE: bus_rdata = base_q;
      OFF_END:  bus_rdata = 32'(endp_q);
      OFF_WP:   bus_rdata = {dir_q, 31'(wptr_q)};
      OFF_RP:   bus_rdata = 32'(rptr_q);
      OFF_CTRL: bus_rdata = ctrl_q;
      OFF_STAT: bus_rdata = {26'b0, st_q, 4'b0};
      default:  bus_rdata = '0;
    endcase
  end

  assign busy   = busy_q;
  assign dir_up = dir_q;
  assign irq    = |(st_q & ctrl_q[5:4]);

  AST_MAGIC_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rp |=> rptr_q == '0); // R4
  AST_RPTR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !clr_rp |=> $stable(rptr_q)); // R6
  AST_DOORBELL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wp && bus_wdata[PW-1:0] != rptr_q |=> busy_q); // R5
  AST_WRONG_DIR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !wr_wp && rptr_q != wptr_q && !(done_up && dir_q) && !(done_dn && !dir_q) |=> busy_q); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[0] && !(wr_st && bus_wdata[4]) |=> st_q[0]); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[5:4] == 2'b00 |-> !irq); // R10

endmodule

// File: tb/dmaq_regs_tb.sv
module dmaq_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        done_up = 1'b0, done_dn = 1'b0;
  logic        busy, dir_up, irq;

  int checks = 0, fails = 0, cyc = 0, wd = 0;
  bit finished = 0;
  int  exp_cyc_q[$];
  bit  exp_dir_q[$];
  logic prev_busy = 1'b0;

  localparam logic [31:0] MAGIC = 32'hEE88_2266;

  dmaq_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_up(done_up),
    .done_dn(done_dn), .busy(busy), .dir_up(dir_up), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  function automatic logic [31:0] rd_now(logic [7:0] a);
    bus_addr = a;
    return 32'(0);
  endfunction

  task automatic doorbell(logic [15:0] p, bit up, int slots, bit expect_end);
    wr(8'h18, {up, 15'b0, p});
    if (expect_end) begin
      exp_cyc_q.push_back(cyc + slots + 1);
      exp_dir_q.push_back(up);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // monitor: pops the expected end of each transfer
  always @(negedge clk) begin
    if (rst_n && prev_busy && !busy) begin
      if (exp_cyc_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7: actual unexpected end at %0d expected none", cyc);
      end else begin
        int ec;
        bit ed;
        ec = exp_cyc_q.pop_front();
        ed = exp_dir_q.pop_front();
        chk("R7 end cycle", 32'(cyc), 32'(ec));
        chk("R7 direction", 32'(dir_up), 32'(ed));
      end
    end
    prev_busy = busy;
  end

  initial begin
    int k, c, rp;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd("R1 ctrl", 8'h20, 0);
    rd("R1 status", 8'h24, 0);
    rd("R1 rptr", 8'h1C, 0);
    rd("R1 wptr", 8'h18, 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 irq", 32'(irq), 0);

    // R2
    wr(8'h10, 32'h1234_5670);
    rd("R2 base", 8'h10, 32'h1234_5670);
    wr(8'h14, 32'hABCD_0040);
    rd("R2 end", 8'h14, 32'h0000_0040);

    // R3
    wr(8'h20, 32'hFFFF_FFFF);
    rd("R3 mask", 8'h20, 32'h300E_0070);
    wr(8'h20, 32'h0002_0030);
    rd("R3 size code 1", 8'h20, 32'h0002_0030);

    // R4 ordinary write ignored
    wr(8'h1C, 32'h0000_1234);
    rd("R4 ignored", 8'h1C, 0);

    // R5/R6/R7 downstream transfer of two slots
    doorbell(16'h0008, 1'b0, 2, 1'b1);
    chk("R5 busy raised", 32'(busy), 1);
    rd("R5 wptr readback", 8'h18, 32'h0000_0008);
    wait_idle();
    rd("R6 rptr after drain", 8'h1C, 32'h8);
    rd("R7 downstream bit", 8'h24, 32'h20);
    chk("R10 irq enabled", 32'(irq), 1);

    // R9
    wr(8'h24, 32'h10);
    rd("R9 zero-bit untouched", 8'h24, 32'h20);
    wr(8'h24, 32'h20);
    rd("R9 cleared", 8'h24, 0);
    chk("R10 irq low", 32'(irq), 0);

    // R4 magic
    wr(8'h1C, MAGIC);
    rd("R4 magic zeroes", 8'h1C, 0);

    // R6 wrap with end 0x10
    wr(8'h14, 32'h10);
    doorbell(16'h000C, 1'b1, 3, 1'b1);
    wait_idle();
    rd("R6 rptr at 0xC", 8'h1C, 32'hC);
    rd("R7 upstream bit", 8'h24, 32'h10);
    doorbell(16'h0004, 1'b1, 2, 1'b1);
    wait_idle();
    rd("R6 wrapped rptr", 8'h1C, 32'h4);

    // R10 mask
    wr(8'h20, 32'h0);
    chk("R10 masked", 32'(irq), 0);
    wr(8'h20, 32'h0002_0030);
    chk("R10 unmasked", 32'(irq), 1);
    wr(8'h24, 32'h30);

    // R5 equal pointer does not start
    doorbell(16'h0004, 1'b1, 0, 1'b0);
    chk("R5 equal no busy", 32'(busy), 0);
    @(negedge clk);
    chk("R5 equal still idle", 32'(busy), 0);

    // R8 completion direction filtering
    wr(8'h14, 32'h400);
    wr(8'h1C, MAGIC);
    doorbell(16'h0200, 1'b1, 0, 1'b0);
    c = cyc;
    repeat (3) @(negedge clk);
    done_dn = 1'b1;
    @(negedge clk);
    done_dn = 1'b0;
    chk("R8 wrong dir keeps busy", 32'(busy), 1);
    rd("R8 dn bit set", 8'h24, 32'h20);
    k = cyc;
    exp_cyc_q.push_back(k + 1);
    exp_dir_q.push_back(1'b1);
    done_up = 1'b1;
    @(negedge clk);
    done_up = 1'b0;
    chk("R8 matching dir ends", 32'(busy), 0);
    rd("R8 both bits", 8'h24, 32'h30);
    rp = 4 * (k + 1 - c);
    rd("R6 rptr at stop", 8'h1C, 32'(rp));
    repeat (2) @(negedge clk);
    rd("R6 rptr holds idle", 8'h1C, 32'(rp));
    wr(8'h24, 32'h30);

    // resume remaining slots
    doorbell(16'h0200, 1'b1, (32'h200 - rp) / 4, 1'b1);
    wait_idle();
    rd("R6 resumed to wptr", 8'h1C, 32'h200);
    rd("R7 upstream after resume", 8'h24, 32'h10);

    // R11
    rd("R11 offset 0x00", 8'h00, 0);
    rd("R11 offset 0x28", 8'h28, 0);

    @(negedge clk);
    chk("R7 all ends seen", 32'(exp_cyc_q.size()), 0);
    finished = 1;
  end

  initial begin
    while (!finished && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule